// File: doc/BRIEF.md
# Direct-Mapped Write-Back Byte Cache

This block is a small direct-mapped cache placed between a processor's byte load/store port and a slower block-organised backing memory. Each processor address is split into a tag, a line index and a byte offset. Every line holds a valid flag, a dirty flag, a stored tag and one block of bytes. Loads and stores that hit finish without touching memory. Stores on a hit change only the cached copy and mark the line dirty. Memory is brought up to date only when a dirty line is displaced.

On a miss the controller displaces the indexed line. If that line is dirty, its whole block is first written to memory at the address formed from its old tag. The controller then reads the whole new block, installs it as clean, and replays the access as a hit. A store miss therefore allocates the line and merges the byte into the fetched block. The processor port uses a request held until a one-cycle ready pulse. The memory port uses a request held until a one-cycle acknowledge, and its latency may vary.

Top module: `dmwb_cache`

## Requirements
- R1: After reset every line is invalid and clean, `cpu_ready`, `hit_evt`, `miss_evt` and `mem_req` are low, and the first access to any address is a miss.
- R2: The address is split as {tag, index, offset}, most significant first (default 2, 2 and 1 bits: 4 lines of 2 bytes). The memory block address is {tag, index}. The byte at offset k occupies bits [8k+7:8k] of a block.
- R3: An access is a hit exactly when the indexed line is valid and its stored tag equals the address tag. A hit raises `hit_evt` with `cpu_ready`, issues no memory request, and completes 2 cycles after the request is first sampled.
- R4: A load returns the most recently stored value of its byte. Every miss reads exactly one full block from memory and installs it as valid and clean.
- R5: A store hit updates only the cached byte, issues no memory traffic and marks the line dirty.
- R6: A miss that displaces a clean or invalid line issues no memory write.
- R7: A miss that displaces a dirty line writes the entire block, with its current contents, to block address {old tag, index}. This write is acknowledged before the refill read is issued.
- R8: A store miss reads the block from memory, merges the stored byte into it and leaves the line dirty.
- R9: `cpu_ready` stays low from the start of a miss until its refill (and any write-back) has finished. Each completed access gives exactly one of `hit_evt` or `miss_evt`, in the same cycle as `cpu_ready`, and `mem_req` is low in that cycle.
- R10: Once raised, `mem_req`, `mem_we` and `mem_addr` stay stable until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | DATA_W | Store byte |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Load byte, valid with `cpu_ready` |
| hit_evt | output | 1 | Completed access was a hit |
| miss_evt | output | 1 | Completed access was a miss |
| mem_req | output | 1 | Block transfer request |
| mem_we | output | 1 | 1 = block write-back, 0 = block read |
| mem_addr | output | ADDR_W-OFF_W | Block address {tag, index} |
| mem_wdata | output | DATA_W<<OFF_W | Block written back |
| mem_ack | input | 1 | One-cycle transfer acknowledge |
| mem_rdata | input | DATA_W<<OFF_W | Block read data, valid with `mem_ack` |

## Verification
The assertions assume that the processor keeps `cpu_req`, `cpu_we`, `cpu_addr` and `cpu_wdata` unchanged until it sees `cpu_ready`. They also assume that memory raises `mem_ack` for a single cycle and only while `mem_req` is high. The bench drives the processor side from one task that raises the request at a falling edge, holds it until the ready pulse and drops it for one idle cycle. The memory responder answers one request at a time after a random delay of zero to three cycles, and it pulses the acknowledge for exactly one cycle. Directed sequences force clean and dirty evictions, store misses over dirty lines and ping-pong conflicts on one index. Seeded random accesses cover the rest of the address space.

// File: rtl/dmwb_pkg.sv
package dmwb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_WB   = 2'd2,
    ST_FILL = 2'd3
  } ctrl_state_t;
endpackage

// File: rtl/dmwb_tag_array.sv
module dmwb_tag_array #(
  parameter int IDX_W = 2,
  parameter int TAG_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  input  logic             fill,
  input  logic [TAG_W-1:0] new_tag,
  input  logic             set_dirty,
  input  logic             inval,
  output logic             vld_o,
  output logic             dty_o,
  output logic [TAG_W-1:0] tag_o
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0] vld_q;
  logic [LINES-1:0] dty_q;
  logic [TAG_W-1:0] tags_q [LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      dty_q <= '0;
    end else if (fill) begin
      vld_q[idx] <= 1'b1;
      dty_q[idx] <= 1'b0;
    end else if (inval) begin
      vld_q[idx] <= 1'b0;
      dty_q[idx] <= 1'b0;
    end else if (set_dirty) begin
      dty_q[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill) tags_q[idx] <= new_tag;
  end

  assign vld_o = vld_q[idx];
  assign dty_o = dty_q[idx];
  assign tag_o = tags_q[idx];

  // R4
  fill_clean_chk: assert property (@(posedge clk) disable iff (rst)
    fill |=> (vld_o && !dty_o));

  // R5
  store_dirty_chk: assert property (@(posedge clk) disable iff (rst)
    set_dirty |=> dty_o);

  // R6
  evict_inval_chk: assert property (@(posedge clk) disable iff (rst)
    inval |=> (!vld_o && !dty_o));
endmodule

// File: rtl/dmwb_data_array.sv
module dmwb_data_array #(
  parameter int IDX_W  = 2,
  parameter int OFF_W  = 1,
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [IDX_W-1:0]           idx,
  input  logic                       blk_we,
  input  logic [(DATA_W<<OFF_W)-1:0] blk_i,
  input  logic                       byte_we,
  input  logic [OFF_W-1:0]           off,
  input  logic [DATA_W-1:0]          byte_i,
  output logic [(DATA_W<<OFF_W)-1:0] blk_o
);
  localparam int LINES = 1 << IDX_W;
  localparam int LANES = 1 << OFF_W;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    logic [DATA_W-1:0] lane_mem [LINES];
    logic              lane_we;
    logic [DATA_W-1:0] lane_wd;

    assign lane_we = blk_we || (byte_we && (int'(off) == b));
    assign lane_wd = blk_we ? blk_i[b*DATA_W +: DATA_W] : byte_i;

    always_ff @(posedge clk) begin
      if (lane_we) lane_mem[idx] <= lane_wd;
    end

    assign blk_o[b*DATA_W +: DATA_W] = lane_mem[idx];
  end

  // R8
  one_writer_chk: assert property (@(posedge clk) disable iff (rst)
    !(blk_we && byte_we));
endmodule

// File: rtl/dmwb_ctrl.sv
module dmwb_ctrl
  import dmwb_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int IDX_W  = 2,
  parameter int OFF_W  = 1,
  parameter int DATA_W = 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            cpu_req,
  input  logic                            cpu_we,
  input  logic [ADDR_W-1:0]               cpu_addr,
  input  logic [DATA_W-1:0]               cpu_wdata,
  output logic                            cpu_ready,
  output logic [DATA_W-1:0]               cpu_rdata,
  output logic                            hit_evt,
  output logic                            miss_evt,
  output logic                            mem_req,
  output logic                            mem_we,
  output logic [ADDR_W-OFF_W-1:0]         mem_addr,
  output logic [(DATA_W<<OFF_W)-1:0]      mem_wdata,
  input  logic                            mem_ack,
  input  logic [(DATA_W<<OFF_W)-1:0]      mem_rdata,
  output logic [IDX_W-1:0]                ln_idx,
  input  logic                            ln_vld,
  input  logic                            ln_dty,
  input  logic [ADDR_W-IDX_W-OFF_W-1:0]   ln_tag,
  input  logic [(DATA_W<<OFF_W)-1:0]      ln_blk,
  output logic                            tg_fill,
  output logic [ADDR_W-IDX_W-OFF_W-1:0]   tg_new_tag,
  output logic                            tg_set_dirty,
  output logic                            tg_inval,
  output logic                            dt_blk_we,
  output logic [(DATA_W<<OFF_W)-1:0]      dt_blk,
  output logic                            dt_byte_we,
  output logic [OFF_W-1:0]                dt_off,
  output logic [DATA_W-1:0]               dt_byte
);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  ctrl_state_t       st_q;
  logic [ADDR_W-1:0] r_addr;
  logic              r_we;
  logic [DATA_W-1:0] r_wdata;
  logic              r_missed;

  logic [TAG_W-1:0]  tag_f;
  logic [IDX_W-1:0]  idx_f;
  logic [OFF_W-1:0]  off_f;
  logic              hit_now;
  logic              victim_dirty;

  assign tag_f        = r_addr[ADDR_W-1 -: TAG_W];
  assign idx_f        = r_addr[OFF_W +: IDX_W];
  assign off_f        = r_addr[OFF_W-1:0];
  assign hit_now      = ln_vld && (ln_tag == tag_f);
  assign victim_dirty = ln_vld && ln_dty;

  assign ln_idx       = idx_f;
  assign tg_new_tag   = tag_f;
  assign tg_fill      = (st_q == ST_FILL) && mem_ack;
  assign dt_blk_we    = tg_fill;
  assign dt_blk       = mem_rdata;
  assign tg_set_dirty = (st_q == ST_LOOK) && hit_now && r_we;
  assign dt_byte_we   = tg_set_dirty;
  assign dt_off       = off_f;
  assign dt_byte      = r_wdata;
  assign tg_inval     = ((st_q == ST_LOOK) && !hit_now && !victim_dirty) ||
                        ((st_q == ST_WB) && mem_ack);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      r_addr    <= '0;
      r_we      <= 1'b0;
      r_wdata   <= '0;
      r_missed  <= 1'b0;
      cpu_ready <= 1'b0;
      cpu_rdata <= '0;
      hit_evt   <= 1'b0;
      miss_evt  <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      cpu_ready <= 1'b0;
      hit_evt   <= 1'b0;
      miss_evt  <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (cpu_req && !cpu_ready) begin
            r_addr   <= cpu_addr;
            r_we     <= cpu_we;
            r_wdata  <= cpu_wdata;
            r_missed <= 1'b0;
            st_q     <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (hit_now) begin
            if (!r_we) cpu_rdata <= ln_blk[int'(off_f)*DATA_W +: DATA_W];
            cpu_ready <= 1'b1;
            hit_evt   <= !r_missed;
            miss_evt  <= r_missed;
            st_q      <= ST_IDLE;
          end else begin
            r_missed <= 1'b1;
            mem_req  <= 1'b1;
            if (victim_dirty) begin
              mem_we    <= 1'b1;
              mem_addr  <= {ln_tag, idx_f};
              mem_wdata <= ln_blk;
              st_q      <= ST_WB;
            end else begin
              mem_we   <= 1'b0;
              mem_addr <= {tag_f, idx_f};
              st_q     <= ST_FILL;
            end
          end
        end
        ST_WB: begin
          if (mem_ack) begin
            mem_we   <= 1'b0;
            mem_addr <= {tag_f, idx_f};
            st_q     <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            st_q    <= ST_LOOK;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R7
  wb_then_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R9
  evt_with_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_evt || miss_evt) |-> (cpu_ready && !(hit_evt && miss_evt)));

  // R9
  ready_idle_mem_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |-> !mem_req);

  // R3
  hit_no_mem_chk: assert property (@(posedge clk) disable iff (rst)
    hit_evt |-> ($past(st_q) == ST_LOOK && !$past(mem_req)));
endmodule

// File: rtl/dmwb_cache.sv
module dmwb_cache #(
  parameter int ADDR_W = 5,
  parameter int IDX_W  = 2,
  parameter int OFF_W  = 1,
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cpu_req,
  input  logic                       cpu_we,
  input  logic [ADDR_W-1:0]          cpu_addr,
  input  logic [DATA_W-1:0]          cpu_wdata,
  output logic                       cpu_ready,
  output logic [DATA_W-1:0]          cpu_rdata,
  output logic                       hit_evt,
  output logic                       miss_evt,
  output logic                       mem_req,
  output logic                       mem_we,
  output logic [ADDR_W-OFF_W-1:0]    mem_addr,
  output logic [(DATA_W<<OFF_W)-1:0] mem_wdata,
  input  logic                       mem_ack,
  input  logic [(DATA_W<<OFF_W)-1:0] mem_rdata
);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam int BLK_W = DATA_W << OFF_W;

  logic [IDX_W-1:0]  ln_idx;
  logic              ln_vld;
  logic              ln_dty;
  logic [TAG_W-1:0]  ln_tag;
  logic [BLK_W-1:0]  ln_blk;
  logic              tg_fill;
  logic [TAG_W-1:0]  tg_new_tag;
  logic              tg_set_dirty;
  logic              tg_inval;
  logic              dt_blk_we;
  logic [BLK_W-1:0]  dt_blk;
  logic              dt_byte_we;
  logic [OFF_W-1:0]  dt_off;
  logic [DATA_W-1:0] dt_byte;

  dmwb_tag_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst(rst), .idx(ln_idx),
    .fill(tg_fill), .new_tag(tg_new_tag),
    .set_dirty(tg_set_dirty), .inval(tg_inval),
    .vld_o(ln_vld), .dty_o(ln_dty), .tag_o(ln_tag)
  );

  dmwb_data_array #(.IDX_W(IDX_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_data (
    .clk(clk), .rst(rst), .idx(ln_idx),
    .blk_we(dt_blk_we), .blk_i(dt_blk),
    .byte_we(dt_byte_we), .off(dt_off), .byte_i(dt_byte),
    .blk_o(ln_blk)
  );

  dmwb_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .hit_evt(hit_evt), .miss_evt(miss_evt),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .ln_idx(ln_idx), .ln_vld(ln_vld), .ln_dty(ln_dty), .ln_tag(ln_tag), .ln_blk(ln_blk),
    .tg_fill(tg_fill), .tg_new_tag(tg_new_tag), .tg_set_dirty(tg_set_dirty),
    .tg_inval(tg_inval), .dt_blk_we(dt_blk_we), .dt_blk(dt_blk),
    .dt_byte_we(dt_byte_we), .dt_off(dt_off), .dt_byte(dt_byte)
  );
endmodule

// File: tb/dmwb_cache_bench.sv
`timescale 1ns/1ps
module dmwb_cache_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0;
  logic        cpu_we = 1'b0;
  logic [4:0]  cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_ready;
  logic [7:0]  cpu_rdata;
  logic        hit_evt;
  logic        miss_evt;
  logic        mem_req;
  logic        mem_we;
  logic [3:0]  mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic [15:0] mem_rdata = '0;

  always #4 clk = ~clk;

  dmwb_cache u_dmwb_cache (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .hit_evt(hit_evt), .miss_evt(miss_evt),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int n_chk = 0;
  int n_fail = 0;

  // architectural byte image, backing store, and reference line state
  logic [7:0]  arch [32];
  logic [15:0] bmem [16];
  logic        mv [4];
  logic        md [4];
  logic [1:0]  mt [4];

  int          wr_cnt, rd_cnt;
  logic [3:0]  wr_addr;
  logic [15:0] wr_data;
  logic        rd_after_wr;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] f_idx(input logic [4:0] a);
    return a[2:1];
  endfunction

  function automatic logic [1:0] f_tag(input logic [4:0] a);
    return a[4:3];
  endfunction

  function automatic logic [15:0] f_blk(input logic [1:0] t, input logic [1:0] i);
    return {arch[{t, i, 1'b1}], arch[{t, i, 1'b0}]};
  endfunction

  // memory responder: one transfer at a time, random 0..3 cycle delay
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && mem_req && !mem_ack) begin
        automatic logic [3:0] a = mem_addr;
        automatic logic       w = mem_we;
        automatic int         lat = $urandom_range(0, 3);
        for (int k = 0; k < lat; k++) begin
          @(negedge clk);
          chk("R10 request held", {27'd0, mem_req, mem_we, mem_addr}, {27'd0, 1'b1, w, a});
        end
        mem_ack = 1'b1;
        if (w) begin
          bmem[a] = mem_wdata;
          wr_cnt++;
          wr_addr = a;
          wr_data = mem_wdata;
        end else begin
          mem_rdata = bmem[a];
          rd_cnt++;
          rd_after_wr = (wr_cnt > 0);
        end
        @(negedge clk);
        mem_ack = 1'b0;
      end
    end
  end

  task automatic access(input logic we, input logic [4:0] addr, input logic [7:0] wd);
    logic [1:0] i, t;
    logic       exp_hit, exp_wb;
    logic [3:0] exp_wa;
    logic [15:0] exp_wd;
    int cyc;
    i = f_idx(addr);
    t = f_tag(addr);
    exp_hit = mv[i] && (mt[i] == t);
    exp_wb  = !exp_hit && mv[i] && md[i];
    exp_wa  = {mt[i], i};
    exp_wd  = f_blk(mt[i], i);
    wr_cnt = 0; rd_cnt = 0; rd_after_wr = 1'b0;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!cpu_ready && cyc < 200);
    chk("R3 R4 hit/miss event", {30'd0, hit_evt, miss_evt}, {30'd0, exp_hit, !exp_hit});
    chk("R9 mem idle at ready", {31'd0, mem_req}, 32'd0);
    if (!we) chk("R4 load data", {24'd0, cpu_rdata}, {24'd0, arch[addr]});
    if (exp_hit) begin
      chk("R3 hit latency", cyc, 2);
      chk("R3 R5 hit memory traffic", rd_cnt + wr_cnt, 0);
    end else begin
      chk("R4 R8 one refill read", rd_cnt, 1);
      chk("R6 R7 write-back count", wr_cnt, {31'd0, exp_wb});
      if (exp_wb) begin
        chk("R2 R7 write-back address", {28'd0, wr_addr}, {28'd0, exp_wa});
        chk("R7 write-back block", {16'd0, wr_data}, {16'd0, exp_wd});
        chk("R7 write before refill", {31'd0, rd_after_wr}, 32'd1);
      end
    end
    if (we) arch[addr] = wd;
    md[i] = exp_hit ? (md[i] | we) : we;
    mv[i] = 1'b1;
    mt[i] = t;
    cpu_req = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    for (int b = 0; b < 16; b++) begin
      arch[2*b]   = 8'($urandom);
      arch[2*b+1] = 8'($urandom);
      bmem[b]     = {arch[2*b+1], arch[2*b]};
    end
    for (int i = 0; i < 4; i++) begin
      mv[i] = 1'b0; md[i] = 1'b0; mt[i] = 2'd0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset outputs", {28'd0, cpu_ready, hit_evt, miss_evt, mem_req}, 32'd0);

    // R1 first accesses miss; R2 offsets within a block
    access(1'b0, 5'h01, 8'h00);
    access(1'b0, 5'h05, 8'h00);
    access(1'b0, 5'h01, 8'h00);   // R3 hit
    access(1'b0, 5'h04, 8'h00);   // R2 other offset, hit
    access(1'b0, 5'h00, 8'h00);
    access(1'b1, 5'h00, 8'hA5);   // R5 store hit
    access(1'b0, 5'h00, 8'h00);   // R5 reads back cached value
    access(1'b0, 5'h08, 8'h00);   // R7 dirty eviction of index 0
    access(1'b1, 5'h19, 8'h3C);   // R8 store miss over clean line (R6)
    access(1'b0, 5'h19, 8'h00);   // R8 merged byte
    access(1'b0, 5'h18, 8'h00);   // R8 fetched neighbour byte
    access(1'b0, 5'h01, 8'h00);   // R7 dirty write-back of merged block
    access(1'b1, 5'h06, 8'h11);   // conflict ping-pong on index 3
    access(1'b1, 5'h0E, 8'h22);
    access(1'b0, 5'h06, 8'h00);
    access(1'b0, 5'h0E, 8'h00);
    access(1'b0, 5'h1F, 8'h00);

    for (int n = 0; n < 400; n++) begin
      access(1'($urandom_range(0, 1)), 5'($urandom_range(0, 31)), 8'($urandom));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule